// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Streamer

This block is the read side of a serial configuration store that feeds a programmable logic device loading itself as bus master. On every rising clock edge while it is selected, it steps an internal bit address and presents the stored bit at that address on a serial data output. The tri-state data pin is modelled as a data value plus an output-enable flag. The stored pattern is fixed at build time by a seed parameter through a small computed function, so the array needs no load path.

Several instances can be chained. Each instance owns a cascade-enable output. When the last stored bit has been presented, the next clock drives that output low and releases the instance's own data line. The following instance has its chip-enable tied to that output, so it takes over the stream without a gap.

A combined reset/output-enable input restarts the stream from bit zero. A parameter chooses whether this input acts on its high or its low level. Chip-enable high puts the instance in standby. A serial-enable input held low suspends readout for programming. In both cases the address is frozen and the data line floats.

Top module: `cfg_stream_reader`

## Requirements
- R1: While `rst_n` is low, and right after it has been released, the address is 0 and `ceo_n` is high. The first enabled cycle presents stored bit 0.
- R2: Stored bit a equals the XOR of all bits of ((37*a + SEED) mod 65536) AND 0x02D5. While enabled, each rising edge advances the address by one, so bits appear in ascending address order.
- R3: On the first clock after address DEPTH-1 has been presented, `ceo_n` goes low and `data_oe` goes low. Both stay that way, with no address wrap, until a reset.
- R4: In a chain where a device's `ce_n` is driven by the previous device's `ceo_n`, the combined stream is the first device's bits followed by the second's. Exactly one device has `data_oe` high in each of those cycles.
- R5: While `rst_oe` is at its active level, `data_oe` is low. The next rising edge clears the address to 0 and sets `ceo_n` high.
- R6: With `RST_OE_ACTIVE_HIGH`=1 the active level of `rst_oe` is high. With 0 it is low.
- R7: With `rst_oe` held at its inactive level, a finished device never restarts. `ceo_n` stays low and `data_oe` stays low.
- R8: While `ce_n` is high, `data_oe` is low whatever the level of `rst_oe`, and the address holds. When `ce_n` returns low, the next bit in sequence is presented.
- R9: While `ser_en_n` is low, readout is suspended: `data_oe` is low and the address holds. When `ser_en_n` returns high, readout resumes at the held address.
- R10: `rst_n` clears the address and sets `ceo_n` high asynchronously. Its release reaches the logic through two synchronizing flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; the address steps on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low; high selects standby |
| rst_oe | input | 1 | Combined reset / output enable; active level set by parameter |
| ser_en_n | input | 1 | Serial enable; low suspends readout for programming |
| data_o | output | 1 | Serial data value (0 while not driving) |
| data_oe | output | 1 | High when `data_o` is driven; low means high impedance |
| ceo_n | output | 1 | Cascade enable to the next device, low once the last bit is read |

## Verification
The bench chains two instances built with different parameters. The first uses DEPTH=24, which is not a power of two, so the last-bit detection cannot rely on the counter overflowing; it uses an active-high `rst_oe`. The second uses DEPTH=9 with an active-low `rst_oe`, fed the inverse of the same wire, so a single reset event exercises both polarities and shows each one clearing its device. Distinct seeds make the two halves of the joined stream distinguishable, so a late or early handoff shows up as wrong bits as well as a double or missing driver.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  localparam int unsigned CONTENT_MUL  = 37;
  localparam logic [15:0] CONTENT_MASK = 16'h02D5;

  // Stored bit for a given address: parity of a scrambled address word.
  function automatic logic content_bit(input int unsigned addr, input logic [15:0] seed);
    logic [15:0] word;
    word = 16'(addr * CONTENT_MUL) + seed;
    return ^(word & CONTENT_MASK);
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int unsigned DEPTH = 64,
  parameter logic [15:0] SEED  = 16'h0000,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned SPAN = 1 << AW
) (
  input  logic [AW-1:0] addr,
  output logic          bit_o
);

  logic [SPAN-1:0] bits;

  // Valid addresses hold computed content; unused addresses hold zero.
  for (genvar g = 0; g < SPAN; g++) begin : g_cell
    if (g < DEPTH) begin : g_used
      assign bits[g] = cfg_stream_pkg::content_bit(g, SEED);
    end else begin : g_pad
      assign bits[g] = 1'b0;
    end
  end

  assign bit_o = bits[addr];

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [AW-1:0] addr_q,
  output logic          done_q
);

  logic [AW-1:0] addr_d;
  logic          done_d;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (clr) begin
      addr_d = '0;
      done_d = 1'b0;
    end else if (run && !done_q) begin
      if (addr_q == LAST) begin
        done_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/cfg_out_ctl.sv
module cfg_out_ctl (
  input  logic run,
  input  logic done,
  input  logic bit_i,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n
);

  always_comb begin
    data_oe = run && !done;
    data_o  = data_oe ? bit_i : 1'b0;
    ceo_n   = !done;
  end

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
  parameter int unsigned DEPTH              = 64,
  parameter logic [15:0] SEED               = 16'h0000,
  parameter bit          RST_OE_ACTIVE_HIGH = 1'b1,
  localparam int unsigned AW                = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rst_oe,
  input  logic ser_en_n,
  output logic data_o,
  output logic data_oe,
  output logic ceo_n
);

  logic          rst_sync_n;
  logic          rst_act;
  logic          run;
  logic [AW-1:0] addr_q;
  logic          done_q;
  logic          cur_bit;

  cfg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  if (RST_OE_ACTIVE_HIGH) begin : g_pol_high
    assign rst_act = rst_oe;
  end else begin : g_pol_low
    assign rst_act = !rst_oe;
  end

  assign run = !ce_n && ser_en_n && !rst_act;

  cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (rst_act),
    .run    (run),
    .addr_q (addr_q),
    .done_q (done_q)
  );

  cfg_bit_store #(.DEPTH(DEPTH), .SEED(SEED)) u_store (
    .addr  (addr_q),
    .bit_o (cur_bit)
  );

  cfg_out_ctl u_out (
    .run     (run),
    .done    (done_q),
    .bit_i   (cur_bit),
    .data_o  (data_o),
    .data_oe (data_oe),
    .ceo_n   (ceo_n)
  );

endmodule

// File: rtl/cfg_stream_reader_chk.sv
module cfg_stream_reader_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          rst_act,
  input logic          ce_n,
  input logic          ser_en_n,
  input logic          data_oe,
  input logic          ceo_n,
  input logic [AW-1:0] addr_q
);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ceo_n && !rst_act) |=> !ceo_n); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_q == LAST && !rst_act) |=> addr_q == LAST); // R3
  AST_HIZ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ceo_n |-> !data_oe); // R3
  AST_CLEAR_ON_RST_OE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_act |=> (addr_q == '0 && ceo_n)); // R5
  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ce_n && !rst_act) |=> $stable(addr_q)); // R8
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_n |-> !data_oe); // R8
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ser_en_n && !rst_act) |=> $stable(addr_q)); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_oe && addr_q != LAST) |=> addr_q == $past(addr_q) + 1'b1); // R2

endmodule

bind cfg_stream_reader cfg_stream_reader_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rst_act    (rst_act),
  .ce_n       (ce_n),
  .ser_en_n   (ser_en_n),
  .data_oe    (data_oe),
  .ceo_n      (ceo_n),
  .addr_q     (addr_q)
);

// File: tb/cfg_stream_reader_test.sv
`timescale 1ns/1ps
module cfg_stream_reader_test;

  localparam int unsigned DA = 24;
  localparam int unsigned DB = 9;
  localparam logic [15:0] SA = 16'h1234;
  localparam logic [15:0] SB = 16'h00F1;

  logic clk = 1'b0;
  logic rst_n, ce_n_a, rst_oe, ser_en_n;
  logic a_d, a_oe, a_ceo_n, b_d, b_oe, b_ceo_n;
  int checks = 0;
  int errors = 0;

  always #4 clk = !clk;

  // Device A: active-high rst_oe. Device B: active-low, fed the inverse wire.
  cfg_stream_reader #(.DEPTH(DA), .SEED(SA), .RST_OE_ACTIVE_HIGH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n_a), .rst_oe(rst_oe), .ser_en_n(ser_en_n),
    .data_o(a_d), .data_oe(a_oe), .ceo_n(a_ceo_n));

  cfg_stream_reader #(.DEPTH(DB), .SEED(SB), .RST_OE_ACTIVE_HIGH(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .ce_n(a_ceo_n), .rst_oe(!rst_oe), .ser_en_n(ser_en_n),
    .data_o(b_d), .data_oe(b_oe), .ceo_n(b_ceo_n));

  function automatic logic exp_bit(input int a, input logic [15:0] seed);
    logic [15:0] w;
    w = 16'(a * 37) + seed;
    return ^(w & 16'h02D5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  // Pulse rst_oe active for one edge; returns at cycle 0 of a fresh stream.
  task automatic restart();
    @(negedge clk); rst_oe = 1'b1;
    @(negedge clk); rst_oe = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    check(a_ceo_n == 1'b1, "R1 ceo_n during reset", a_ceo_n, 1);
    check(a_oe == 1'b0 && b_oe == 1'b0, "R1 R5 no driver while rst_oe active", a_oe + b_oe, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_oe = 1'b0;
    #1;
    check(a_oe == 1'b1 && a_d == exp_bit(0, SA), "R1 first bit after reset", a_d, exp_bit(0, SA));
    check(a_ceo_n == 1'b1, "R1 ceo_n high after reset", a_ceo_n, 1);
  endtask

  task automatic t_chain_stream();
    restart();
    for (int k = 0; k < int'(DA + DB); k++) begin
      logic exp, got;
      if (k > 0) next_cycle();
      exp = (k < int'(DA)) ? exp_bit(k, SA) : exp_bit(k - int'(DA), SB);
      got = a_oe ? a_d : b_d;
      check(int'(a_oe) + int'(b_oe) == 1, "R4 one driver", int'(a_oe) + int'(b_oe), 1);
      check(got == exp, "R2 R4 stream bit", got, exp);
      if (k == int'(DA))
        check(a_ceo_n == 1'b0 && a_oe == 1'b0, "R3 handoff after last bit", a_ceo_n, 0);
      if (k == int'(DA) - 1)
        check(a_ceo_n == 1'b1, "R3 ceo_n still high on last bit", a_ceo_n, 1);
    end
    next_cycle();
    check(a_oe == 1'b0 && b_oe == 1'b0, "R3 both released at end", a_oe + b_oe, 0);
    check(b_ceo_n == 1'b0, "R3 second device cascade low", b_ceo_n, 0);
  endtask

  task automatic t_no_restart();
    bit ok = 1'b1;
    for (int k = 0; k < 40; k++) begin
      next_cycle();
      if (a_ceo_n !== 1'b0 || a_oe !== 1'b0 || b_oe !== 1'b0) ok = 1'b0;
    end
    check(ok, "R7 finished chain stays idle", ok, 1);
  endtask

  task automatic t_rst_oe_polarity();
    @(negedge clk); rst_oe = 1'b1;
    #1;
    check(a_ceo_n == 1'b0, "R5 clear waits for clock edge", a_ceo_n, 0);
    check(a_oe == 1'b0 && b_oe == 1'b0, "R5 R6 released while active", a_oe + b_oe, 0);
    @(negedge clk); rst_oe = 1'b0;
    #1;
    check(a_ceo_n == 1'b1 && a_oe == 1'b1 && a_d == exp_bit(0, SA), "R5 R6 high-active clear", a_d, exp_bit(0, SA));
    check(b_ceo_n == 1'b1, "R6 low-active device cleared", b_ceo_n, 1);
    for (int k = 1; k <= int'(DA); k++) next_cycle();
    check(b_oe == 1'b1 && b_d == exp_bit(0, SB), "R6 low-active device restarts at bit 0", b_d, exp_bit(0, SB));
  endtask

  task automatic t_standby();
    restart();
    for (int k = 1; k < 5; k++) next_cycle();
    check(a_d == exp_bit(4, SA), "R2 bit 4 before standby", a_d, exp_bit(4, SA));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); ce_n_a = 1'b1;
      #1;
      check(a_oe == 1'b0, "R8 standby floats data", a_oe, 0);
    end
    @(negedge clk); ce_n_a = 1'b0;
    #1;
    check(a_oe == 1'b1 && a_d == exp_bit(5, SA), "R8 resumes at next bit", a_d, exp_bit(5, SA));
  endtask

  task automatic t_prog_mode();
    restart();
    for (int k = 1; k < 7; k++) next_cycle();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ser_en_n = 1'b0;
      #1;
      check(a_oe == 1'b0 && b_oe == 1'b0, "R9 programming mode floats data", a_oe + b_oe, 0);
    end
    @(negedge clk); ser_en_n = 1'b1;
    #1;
    check(a_oe == 1'b1 && a_d == exp_bit(7, SA), "R9 resumes at held address", a_d, exp_bit(7, SA));
  endtask

  task automatic t_async_reset();
    restart();
    for (int k = 1; k <= int'(DA); k++) next_cycle();
    check(a_ceo_n == 1'b0, "R3 done before async reset", a_ceo_n, 0);
    #1 rst_n = 1'b0;
    #1;
    check(a_ceo_n == 1'b1, "R10 async clear of cascade", a_ceo_n, 1);
    check(a_oe == 1'b1 && a_d == exp_bit(0, SA), "R10 R1 address back to 0", a_d, exp_bit(0, SA));
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(a_d == exp_bit(0, SA), "R10 held during synchronized release", a_d, exp_bit(0, SA));
    repeat (3) next_cycle();
  endtask

  initial begin
    rst_n = 1'b0; rst_oe = 1'b1; ce_n_a = 1'b0; ser_en_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    t_reset_state();
    t_chain_stream();
    t_no_restart();
    t_rst_oe_polarity();
    t_standby();
    t_prog_mode();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule